// File: doc/BRIEF.md
# Serial Port Channel Data Buffer

This block sits between a processor core and the shift logic of a frame-synchronized serial port. It holds two independent channel buffers, A and B. Each one is set up either as a transmit buffer or as a receive buffer. In transmit mode the core writes words and each frame-sync pulse moves the oldest word out to the serial side. In receive mode each frame-sync pulse stores a word from the serial side and the core reads words out.

Each channel reports a two-bit fill code and a sticky error flag. The flag marks a frame-sync pulse that found a transmit buffer empty (underflow) or a receive buffer full (overflow). On overflow the incoming word replaces the newest stored word, so the most recent serial data is never lost. Both channels' codes and flags are packed into one read-only 32-bit status word. The shift registers, the serial clock and the frame-sync generation lie outside this block. A frame-sync event reaches it as a one-cycle pulse, and it behaves the same whether that pulse was generated on chip or off chip.

Top module: `spbuf_top`

## Requirements
- R1: Every frame-sync pulse on an enabled channel moves exactly one word. In transmit mode, a non-empty buffer drives its oldest word onto the serial data output one cycle after the pulse. In receive mode, a non-full buffer stores the serial input word, and core reads return the words oldest first.
- R2: A frame-sync pulse on an empty transmit buffer sets the error flag one cycle later. The serial data output keeps its previous value (zero after reset) and the buffer stays empty.
- R3: A frame-sync pulse on a full receive buffer sets the error flag. The incoming word replaces the most recently stored word and the buffer stays full.
- R4: The fill code is 2'b00 when empty, 2'b10 when partly full and 2'b11 when holding DEPTH words. The code 2'b01 never appears.
- R5: The status word carries the channel B error flag at bit 26, the channel B fill code at bits 28:27, the channel A error flag at bit 29 and the channel A fill code at bits 31:30. All other bits read zero.
- R6: The error flag stays set until a clear pulse or a disable. A new error in the same cycle as a clear leaves the flag set.
- R7: Driving a channel's enable low empties its buffer and clears its error flag at the next clock edge.
- R8: A core write to a full transmit buffer is dropped. A core read from an empty receive buffer leaves the read data and the fill code unchanged.
- R9: Core writes have no effect in receive mode, and core reads have no effect in transmit mode.
- R10: Channels A and B are independent. Activity on one never changes the other's data, fill code or error flag.
- R11: After reset, the status word and both channels' data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_enable | input | 1 | Channel A enable; low empties the buffer and clears the flag |
| a_is_rx | input | 1 | Channel A direction: 1 receive, 0 transmit |
| a_clr_err | input | 1 | Channel A error clear pulse |
| a_fs | input | 1 | Channel A frame-sync pulse |
| a_core_wr | input | 1 | Channel A core write strobe (transmit mode) |
| a_core_wdata | input | DATA_W | Channel A core write word |
| a_core_rd | input | 1 | Channel A core read strobe (receive mode) |
| a_core_rdata | output | DATA_W | Channel A core read word |
| a_ser_rx_data | input | DATA_W | Channel A word from the serial side |
| a_ser_tx_data | output | DATA_W | Channel A word to the serial side |
| b_enable | input | 1 | Channel B enable |
| b_is_rx | input | 1 | Channel B direction |
| b_clr_err | input | 1 | Channel B error clear pulse |
| b_fs | input | 1 | Channel B frame-sync pulse |
| b_core_wr | input | 1 | Channel B core write strobe |
| b_core_wdata | input | DATA_W | Channel B core write word |
| b_core_rd | input | 1 | Channel B core read strobe |
| b_core_rdata | output | DATA_W | Channel B core read word |
| b_ser_rx_data | input | DATA_W | Channel B word from the serial side |
| b_ser_tx_data | output | DATA_W | Channel B word to the serial side |
| status_word | output | 32 | Packed fill codes and error flags |

## Verification
On every cycle, the assertions check the following: the forbidden fill code never appears, underflow and overflow set the flag while the fill level holds, the flag stays set, disable clears the channel, and dropped or wrong-mode core accesses leave the fill code alone. Other behaviours need the bench's scoreboard scenarios. These are the word ordering through the buffer, which word an overflow replaces, the held serial and read data after an underflow or an empty read, the packing of the whole status word, and the independence of the two channels.

// File: rtl/spbuf_pkg.sv
package spbuf_pkg;
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_PART  = 2'b10,
    FILL_FULL  = 2'b11
  } fill_code_e;

  function automatic fill_code_e fill_of(input logic is_empty, input logic is_full);
    if (is_empty)     return FILL_EMPTY;
    else if (is_full) return FILL_FULL;
    else              return FILL_PART;
  endfunction
endpackage

// File: rtl/spbuf_store.sv
module spbuf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write port: no reset so the array maps onto RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, holds its value when no read is made
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spbuf_chan.sv
module spbuf_chan
  import spbuf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              is_rx,
  input  logic              clr_err,
  input  logic              fs,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_rd,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic [DATA_W-1:0] core_rdata,
  output logic [DATA_W-1:0] ser_tx_data,
  output logic [1:0]        fill,
  output logic              err
);
  logic [CW-1:0] count_q, count_n;
  logic [AW-1:0] rd_ptr, wr_ptr, newest;
  logic          is_empty, is_full;
  logic          tx_push, tx_pop, tx_under;
  logic          rx_push, rx_pop, rx_over;
  logic          push, pop, we;
  logic [AW-1:0] waddr;
  logic [DATA_W-1:0] wdata, rd_word;
  fill_code_e    fill_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign is_empty = (count_q == '0);
  assign is_full  = (count_q == CW'(DEPTH));

  // all decisions use the occupancy before this cycle's accesses
  assign tx_push  = enable & ~is_rx & core_wr & ~is_full;
  assign tx_pop   = enable & ~is_rx & fs & ~is_empty;
  assign tx_under = enable & ~is_rx & fs & is_empty;
  assign rx_push  = enable & is_rx & fs & ~is_full;
  assign rx_over  = enable & is_rx & fs & is_full;
  assign rx_pop   = enable & is_rx & core_rd & ~is_empty;

  assign push   = tx_push | rx_push;
  assign pop    = tx_pop | rx_pop;
  assign newest = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - AW'(1);
  assign we     = push | rx_over;
  assign waddr  = rx_over ? newest : wr_ptr;
  assign wdata  = is_rx ? ser_rx_data : core_wdata;

  always_comb begin
    if (!enable) count_n = '0;
    else         count_n = count_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      fill_q  <= FILL_EMPTY;
      err     <= 1'b0;
    end else begin
      count_q <= count_n;
      fill_q  <= fill_of(count_n == '0, count_n == CW'(DEPTH));
      if (!enable) begin
        rd_ptr <= '0;
        wr_ptr <= '0;
        err    <= 1'b0;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr);
        if (pop)  rd_ptr <= bump(rd_ptr);
        if (tx_under | rx_over) err <= 1'b1;
        else if (clr_err)       err <= 1'b0;
      end
    end
  end

  spbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .re    (pop),
    .raddr (rd_ptr),
    .rdata (rd_word)
  );

  // one read register serves both directions; only one is active per mode
  assign core_rdata  = rd_word;
  assign ser_tx_data = rd_word;
  assign fill        = fill_q;
endmodule

// File: rtl/spbuf_top.sv
module spbuf_top #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_enable,
  input  logic              a_is_rx,
  input  logic              a_clr_err,
  input  logic              a_fs,
  input  logic              a_core_wr,
  input  logic [DATA_W-1:0] a_core_wdata,
  input  logic              a_core_rd,
  output logic [DATA_W-1:0] a_core_rdata,
  input  logic [DATA_W-1:0] a_ser_rx_data,
  output logic [DATA_W-1:0] a_ser_tx_data,
  input  logic              b_enable,
  input  logic              b_is_rx,
  input  logic              b_clr_err,
  input  logic              b_fs,
  input  logic              b_core_wr,
  input  logic [DATA_W-1:0] b_core_wdata,
  input  logic              b_core_rd,
  output logic [DATA_W-1:0] b_core_rdata,
  input  logic [DATA_W-1:0] b_ser_rx_data,
  output logic [DATA_W-1:0] b_ser_tx_data,
  output logic [STAT_W-1:0] status_word
);
  localparam int NCH     = 2;
  localparam int B_ERR_B = 26;
  localparam int B_ST_LO = 27;
  localparam int A_ERR_B = 29;
  localparam int A_ST_LO = 30;

  logic [NCH-1:0]    en_v, rx_v, clr_v, fs_v, wr_v, rd_v, err_v;
  logic [DATA_W-1:0] wd_v [NCH];
  logic [DATA_W-1:0] sr_v [NCH];
  logic [DATA_W-1:0] rdd_v [NCH];
  logic [DATA_W-1:0] txd_v [NCH];
  logic [1:0]        fill_v [NCH];

  // index 0 is channel A, index 1 is channel B
  assign en_v  = {b_enable,  a_enable};
  assign rx_v  = {b_is_rx,   a_is_rx};
  assign clr_v = {b_clr_err, a_clr_err};
  assign fs_v  = {b_fs,      a_fs};
  assign wr_v  = {b_core_wr, a_core_wr};
  assign rd_v  = {b_core_rd, a_core_rd};
  assign wd_v[0] = a_core_wdata;
  assign wd_v[1] = b_core_wdata;
  assign sr_v[0] = a_ser_rx_data;
  assign sr_v[1] = b_ser_rx_data;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    spbuf_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .enable      (en_v[c]),
      .is_rx       (rx_v[c]),
      .clr_err     (clr_v[c]),
      .fs          (fs_v[c]),
      .core_wr     (wr_v[c]),
      .core_wdata  (wd_v[c]),
      .core_rd     (rd_v[c]),
      .ser_rx_data (sr_v[c]),
      .core_rdata  (rdd_v[c]),
      .ser_tx_data (txd_v[c]),
      .fill        (fill_v[c]),
      .err         (err_v[c])
    );
  end

  assign a_core_rdata  = rdd_v[0];
  assign a_ser_tx_data = txd_v[0];
  assign b_core_rdata  = rdd_v[1];
  assign b_ser_tx_data = txd_v[1];

  always_comb begin
    status_word                  = '0;
    status_word[A_ST_LO +: 2]    = fill_v[0];
    status_word[A_ERR_B]         = err_v[0];
    status_word[B_ST_LO +: 2]    = fill_v[1];
    status_word[B_ERR_B]         = err_v[1];
  end
endmodule

// File: rtl/spbuf_chk.sv
module spbuf_chk (
  input logic        clk,
  input logic        rst,
  input logic        a_enable,
  input logic        a_is_rx,
  input logic        a_clr_err,
  input logic        a_fs,
  input logic        a_core_wr,
  input logic        a_core_rd,
  input logic        b_enable,
  input logic        b_is_rx,
  input logic        b_fs,
  input logic        b_core_rd,
  input logic [31:0] status_word
);
  logic [1:0] st_a, st_b;
  logic       er_a, er_b;
  assign st_a = status_word[31:30];
  assign er_a = status_word[29];
  assign st_b = status_word[28:27];
  assign er_b = status_word[26];

  a_r4_code_a: assert property (@(posedge clk) disable iff (rst) st_a != 2'b01);
  a_r4_code_b: assert property (@(posedge clk) disable iff (rst) st_b != 2'b01);

  a_r2_underflow: assert property (@(posedge clk) disable iff (rst)
    (a_enable && !a_is_rx && a_fs && !a_core_wr && st_a == 2'b00) |=> (er_a && st_a == 2'b00));

  a_r3_overflow: assert property (@(posedge clk) disable iff (rst)
    (b_enable && b_is_rx && b_fs && !b_core_rd && st_b == 2'b11) |=> (er_b && st_b == 2'b11));

  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (a_enable && er_a && !a_clr_err) |=> er_a);

  a_r7_disable_a: assert property (@(posedge clk) disable iff (rst)
    !a_enable |=> (st_a == 2'b00 && !er_a));

  a_r7_disable_b: assert property (@(posedge clk) disable iff (rst)
    !b_enable |=> (st_b == 2'b00 && !er_b));

  a_r8_full_write: assert property (@(posedge clk) disable iff (rst)
    (a_enable && !a_is_rx && a_core_wr && !a_fs && st_a == 2'b11) |=> st_a == 2'b11);

  a_r9_rx_write: assert property (@(posedge clk) disable iff (rst)
    (a_enable && a_is_rx && a_core_wr && !a_fs && !a_core_rd) |=> $stable(st_a));
endmodule

bind spbuf_top spbuf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .a_enable    (a_enable),
  .a_is_rx     (a_is_rx),
  .a_clr_err   (a_clr_err),
  .a_fs        (a_fs),
  .a_core_wr   (a_core_wr),
  .a_core_rd   (a_core_rd),
  .b_enable    (b_enable),
  .b_is_rx     (b_is_rx),
  .b_fs        (b_fs),
  .b_core_rd   (b_core_rd),
  .status_word (status_word)
);

// File: tb/tb_spbuf_top.sv
module tb_spbuf_top;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_enable = 0, a_is_rx = 0, a_clr_err = 0, a_fs = 0, a_core_wr = 0, a_core_rd = 0;
  logic b_enable = 0, b_is_rx = 0, b_clr_err = 0, b_fs = 0, b_core_wr = 0, b_core_rd = 0;
  logic [DW-1:0] a_core_wdata = '0, a_ser_rx_data = '0, b_core_wdata = '0, b_ser_rx_data = '0;
  logic [DW-1:0] a_core_rdata, a_ser_tx_data, b_core_rdata, b_ser_tx_data;
  logic [31:0]   status_word;

  always #(CLK_P/2) clk = ~clk;

  spbuf_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut (.*);

  // scoreboard item: kind 0 fill code, 1 error flag, 2 serial tx word, 3 core read word, 4 whole status word
  typedef struct {
    int          ch;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] qa[$], qb[$];
  bit            erra = 0, errb = 0;
  logic [DW-1:0] outa = '0, outb = '0;

  function automatic logic [1:0] code_of(input int n);
    if (n == 0)          return 2'b00;
    else if (n == DEPTH) return 2'b11;
    else                 return 2'b10;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[31:30] = code_of(qa.size());
    s[29]    = erra;
    s[28:27] = code_of(qb.size());
    s[26]    = errb;
    return s;
  endfunction

  task automatic expect_item(input int ch, input int kind, input logic [31:0] exp, input string req);
    item_t it;
    it.ch = ch; it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = (it.ch == 0) ? {30'b0, status_word[31:30]} : {30'b0, status_word[28:27]};
        1: act = (it.ch == 0) ? {31'b0, status_word[29]} : {31'b0, status_word[26]};
        2: act = (it.ch == 0) ? a_ser_tx_data : b_ser_tx_data;
        3: act = (it.ch == 0) ? a_core_rdata : b_core_rdata;
        default: act = status_word;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s ch%0d kind%0d actual=%h expected=%h", it.req, it.ch, it.kind, act, it.exp);
      end
    end
  end

  // driver: applies one cycle of stimulus, advances the reference model, queues expectations
  task automatic op(input int ch, input bit fs, input bit wr, input logic [DW-1:0] wd,
                    input bit rd, input logic [DW-1:0] rxd, input bit clr, input string req);
    logic [DW-1:0] q[$];
    bit en, rx, er, hit;
    logic [DW-1:0] o;
    int pre;
    if (ch == 0) begin
      q = qa; en = a_enable; rx = a_is_rx; er = erra; o = outa;
      a_fs = fs; a_core_wr = wr; a_core_wdata = wd; a_core_rd = rd; a_ser_rx_data = rxd; a_clr_err = clr;
    end else begin
      q = qb; en = b_enable; rx = b_is_rx; er = errb; o = outb;
      b_fs = fs; b_core_wr = wr; b_core_wdata = wd; b_core_rd = rd; b_ser_rx_data = rxd; b_clr_err = clr;
    end
    pre = q.size();
    hit = 0;
    if (!en) begin
      q.delete(); er = 0;
    end else if (!rx) begin
      if (fs) begin
        if (pre > 0) o = q.pop_front();
        else hit = 1;
      end
      if (wr && pre < DEPTH) q.push_back(wd);
    end else begin
      if (rd && pre > 0) o = q[0];
      if (fs) begin
        if (pre < DEPTH) q.push_back(rxd);
        else begin q[q.size()-1] = rxd; hit = 1; end
      end
      if (rd && pre > 0) void'(q.pop_front());
    end
    if (en) begin
      if (hit) er = 1;
      else if (clr) er = 0;
    end
    @(posedge clk);
    #1;
    a_fs = 0; a_core_wr = 0; a_core_rd = 0; a_clr_err = 0;
    b_fs = 0; b_core_wr = 0; b_core_rd = 0; b_clr_err = 0;
    if (ch == 0) begin qa = q; erra = er; outa = o; end
    else         begin qb = q; errb = er; outb = o; end
    expect_item(ch, 0, {30'b0, code_of(q.size())}, req);
    expect_item(ch, 1, {31'b0, er}, req);
    expect_item(ch, rx ? 3 : 2, o, req);
  endtask

  task automatic idle(input int ch, input string req);
    op(ch, 0, 0, '0, 0, '0, 0, req);
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst = 0;
    expect_item(0, 4, 32'h0, "R11 status after reset");
    expect_item(0, 2, '0, "R11 a tx data after reset");
    expect_item(1, 3, '0, "R11 b read data after reset");
    @(posedge clk); #1;

    a_enable = 1; a_is_rx = 0;
    b_enable = 1; b_is_rx = 1;
    idle(0, "R4 enabled empty");

    // channel A transmit
    op(0, 1, 0, '0, 0, '0, 0, "R2 underflow on empty tx");
    idle(0, "R6 flag sticky");
    op(0, 0, 0, '0, 0, '0, 1, "R6 clear pulse");
    op(0, 0, 1, 32'hA1A1_0001, 0, '0, 0, "R4 partial after one write");
    expect_item(0, 4, exp_status(), "R5 packed status partial");
    op(0, 0, 1, 32'hA1A1_0002, 0, '0, 0, "R4 full after two writes");
    op(0, 0, 1, 32'hDEAD_BEEF, 0, '0, 0, "R8 write to full tx dropped");
    op(0, 0, 0, '0, 1, '0, 0, "R9 read in tx mode ignored");
    op(0, 1, 0, '0, 0, '0, 0, "R1 tx sends oldest");
    op(0, 1, 1, 32'hA1A1_0003, 0, '0, 0, "R1 tx send with write");
    op(0, 1, 0, '0, 0, '0, 0, "R1 tx sends third");
    op(0, 1, 0, '0, 0, '0, 1, "R6 underflow beats clear, R2 data held");
    expect_item(0, 4, exp_status(), "R5 packed status with A error");

    // channel B receive
    op(1, 1, 0, '0, 0, 32'hB0B0_0001, 0, "R1 rx accepts first");
    op(1, 1, 0, '0, 0, 32'hB0B0_0002, 0, "R4 rx full");
    op(1, 0, 1, 32'h1234_5678, 0, '0, 0, "R9 write in rx mode ignored");
    op(1, 1, 0, '0, 0, 32'hB0B0_0003, 0, "R3 overflow replaces newest");
    expect_item(0, 4, exp_status(), "R10 A unaffected by B, R5 packing");
    op(1, 0, 0, '0, 1, '0, 0, "R1 rx reads oldest");
    op(1, 0, 0, '0, 1, '0, 0, "R3 overwritten word read");
    op(1, 0, 0, '0, 1, '0, 0, "R8 read empty holds");
    op(1, 1, 0, '0, 0, 32'hB0B0_0004, 0, "R1 rx refill");
    op(1, 1, 0, '0, 0, 32'hB0B0_0005, 0, "R1 rx refill full");
    op(1, 1, 0, '0, 1, 32'hB0B0_0006, 0, "R3 overflow with read");
    op(1, 0, 0, '0, 1, '0, 0, "R3 read after overflow");

    // disable
    a_enable = 0;
    idle(0, "R7 disable A clears");
    expect_item(1, 4, exp_status(), "R10 B unaffected by A disable");
    a_enable = 1; a_is_rx = 1;
    op(0, 1, 0, '0, 0, 32'hC0C0_0001, 0, "R1 A as receiver");
    op(0, 0, 1, 32'h5555_5555, 0, '0, 0, "R9 A rx write ignored");
    b_enable = 0;
    idle(1, "R7 disable B clears");
    b_enable = 1; b_is_rx = 0;
    op(1, 0, 1, 32'hD0D0_0001, 0, '0, 0, "R1 B as transmitter");
    op(1, 1, 0, '0, 0, '0, 0, "R1 B sends word");
    expect_item(0, 4, exp_status(), "R5 final status");

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule